// File: doc/BRIEF.md
# Touch Output Mode Timer

This block turns one channel's debounced touch level into the level driven on that channel's output pin. After reset it reads a pair of strap inputs once. The pair selects how the output behaves. In follow mode the output tracks the touch level. In toggle mode each new touch flips the output. The pair also sets the longest time the output may stay on: none, short or long.

The on-time is counted in clock cycles. A prescaler of `TICK_DIV` cycles makes a seconds tick, and a seconds counter compares against `SHORT_SEC` or `LONG_SEC`. All timeouts therefore scale inversely with the clock frequency. When the limit is reached, the output is forced low and a one-cycle timeout pulse is given. The output then stays low until the touch level has gone low. One instance serves one channel.

Top module: `touch_out_timer`

## Requirements
- R1: The straps are captured on the first clock edge after reset release. Later changes on `strap_a_i`/`strap_b_i` have no effect until the next reset.
- R2: `out_o` and `timeout_o` are low during reset and on the edge that captures the straps.
- R3: Strap code `strap_a_i=0, strap_b_i=0` selects follow mode with no on-time limit. The output stays high for as long as the touch is held.
- R4: Strap code `strap_a_i=0, strap_b_i=1` selects follow mode with a limit of `SHORT_SEC*TICK_DIV` cycles.
- R5: Strap code `strap_a_i=1, strap_b_i=0` selects follow mode with a limit of `LONG_SEC*TICK_DIV` cycles.
- R6: Strap code `strap_a_i=1, strap_b_i=1` selects toggle mode with a limit of `SHORT_SEC*TICK_DIV` cycles.
- R7: In follow mode, when the output is not blocked, `out_o` equals the `touch_i` value sampled one clock edge earlier.
- R8: With a limit active, `out_o` stays high for exactly the limit in cycles. It then goes low, and `timeout_o` is high for exactly that first low cycle.
- R9: After a timeout, `out_o` stays low while `touch_i` remains high. The output can be set again only after `touch_i` has been low for at least one cycle.
- R10: In toggle mode, each rising edge of `touch_i` inverts `out_o`. Holding or releasing the touch leaves `out_o` unchanged.
- R11: The on-time count restarts at every rising edge of `out_o`. It clears when `out_o` falls, so each new on-period gets the full limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all timing is counted in its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_a_i | input | 1 | First strap bit, captured once after reset |
| strap_b_i | input | 1 | Second strap bit, captured once after reset |
| touch_i | input | 1 | Debounced touch level of the channel |
| out_o | output | 1 | Channel output level |
| timeout_o | output | 1 | One-cycle pulse when the on-time limit forces the output low |

## Verification
A wrong captured configuration shows at the ports within one cycle of the first touch release. A follow output that stays high, or a toggle output that drops, gives it away. A seconds counter or prescaler that is off by one shifts the fall of `out_o` and the `timeout_o` pulse by at least one cycle. The exact-length on-period checks catch this at the very first timeout. A block flag that is stuck or cleared too early shows one cycle after the timeout, as an output that re-asserts while the touch is still held, or that fails to assert on the next press.

// File: rtl/tout_pkg.sv
package tout_pkg;

   typedef enum logic [1:0] {
      LIM_NONE  = 2'd0,
      LIM_SHORT = 2'd1,
      LIM_LONG  = 2'd2
   } lim_e;

   typedef struct packed {
      logic toggle;
      lim_e lim;
   } tout_cfg_t;

   // strap pair {a,b} -> behaviour
   function automatic tout_cfg_t decode_straps(input logic a, input logic b);
      tout_cfg_t c;
      unique case ({a, b})
         2'b00:   begin c.toggle = 1'b0; c.lim = LIM_NONE;  end
         2'b01:   begin c.toggle = 1'b0; c.lim = LIM_SHORT; end
         2'b10:   begin c.toggle = 1'b0; c.lim = LIM_LONG;  end
         default: begin c.toggle = 1'b1; c.lim = LIM_SHORT; end
      endcase
      return c;
   endfunction

endpackage

// File: rtl/tout_strap_capture.sv
module tout_strap_capture
   import tout_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      strap_a_i,
   input  logic      strap_b_i,
   output tout_cfg_t cfg_o,
   output logic      cfg_done_o
);

   tout_cfg_t cfg_q;
   logic      done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         cfg_q  <= '{toggle: 1'b0, lim: LIM_NONE};
      end else if (!done_q) begin
         done_q <= 1'b1;
         cfg_q  <= decode_straps(strap_a_i, strap_b_i);
      end
   end

   assign cfg_o      = cfg_q;
   assign cfg_done_o = done_q;

endmodule

// File: rtl/tout_prescaler.sv
module tout_prescaler #(
   parameter int TICK_DIV = 10_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic tick_o
);

   localparam int  CW       = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
   localparam bit  IS_POW2  = ((TICK_DIV & (TICK_DIV - 1)) == 0);

   logic [CW-1:0] cnt_q;

   generate
      if (TICK_DIV < 2) begin : g_bad_div
         $error("tout_prescaler: TICK_DIV must be at least 2");
      end

      if (IS_POW2) begin : g_pow2
         assign tick_o = run_i & (&cnt_q);
         always_ff @(posedge clk) begin
            if (!rst_n || !run_i) cnt_q <= '0;
            else                  cnt_q <= cnt_q + 1'b1;
         end
      end else begin : g_cmp
         assign tick_o = run_i & (cnt_q == CW'(TICK_DIV - 1));
         always_ff @(posedge clk) begin
            if (!rst_n || !run_i) cnt_q <= '0;
            else if (tick_o)      cnt_q <= '0;
            else                  cnt_q <= cnt_q + 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/tout_on_timer.sv
module tout_on_timer
   import tout_pkg::*;
#(
   parameter int TICK_DIV  = 10_000_000,
   parameter int SHORT_SEC = 10,
   parameter int LONG_SEC  = 60
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  lim_e lim_i,
   output logic expire_o
);

   localparam int SW = $clog2(LONG_SEC + 1);

   logic          tick;
   logic [SW-1:0] sec_q;
   logic [SW-1:0] last_sec;

   generate
      if (SHORT_SEC < 1 || LONG_SEC < SHORT_SEC) begin : g_bad_sec
         $error("tout_on_timer: need 1 <= SHORT_SEC <= LONG_SEC");
      end
   endgenerate

   tout_prescaler #(.TICK_DIV(TICK_DIV)) presc_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (run_i),
      .tick_o (tick)
   );

   assign last_sec = (lim_i == LIM_LONG) ? SW'(LONG_SEC - 1) : SW'(SHORT_SEC - 1);

   always_ff @(posedge clk) begin
      if (!rst_n || !run_i) sec_q <= '0;
      else if (tick)        sec_q <= sec_q + 1'b1;
   end

   assign expire_o = run_i & tick & (lim_i != LIM_NONE) & (sec_q == last_sec);

endmodule

// File: rtl/tout_out_ctrl.sv
module tout_out_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic toggle_i,
   input  logic touch_i,
   input  logic expire_i,
   output logic out_o,
   output logic timeout_o,
   output logic blk_o
);

   logic touch_q, out_q, to_q, blk_q;
   logic rise, out_d;

   assign rise = touch_i & ~touch_q;

   always_comb begin
      if (!en_i || expire_i)  out_d = 1'b0;
      else if (toggle_i)      out_d = (rise & ~blk_q) ? ~out_q : out_q;
      else                    out_d = touch_i & ~blk_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         touch_q <= 1'b0;
         out_q   <= 1'b0;
         to_q    <= 1'b0;
         blk_q   <= 1'b0;
      end else begin
         touch_q <= touch_i;
         out_q   <= out_d;
         to_q    <= expire_i;
         blk_q   <= touch_i & (blk_q | expire_i);
      end
   end

   assign out_o     = out_q;
   assign timeout_o = to_q;
   assign blk_o     = blk_q;

endmodule

// File: rtl/touch_out_timer.sv
module touch_out_timer
   import tout_pkg::*;
#(
   parameter int TICK_DIV  = 10_000_000,
   parameter int SHORT_SEC = 10,
   parameter int LONG_SEC  = 60
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strap_a_i,
   input  logic strap_b_i,
   input  logic touch_i,
   output logic out_o,
   output logic timeout_o
);

   tout_cfg_t cfg;
   logic      cfg_done;
   logic      expire;
   logic      blk;

   tout_strap_capture cap_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .strap_a_i  (strap_a_i),
      .strap_b_i  (strap_b_i),
      .cfg_o      (cfg),
      .cfg_done_o (cfg_done)
   );

   tout_on_timer #(
      .TICK_DIV  (TICK_DIV),
      .SHORT_SEC (SHORT_SEC),
      .LONG_SEC  (LONG_SEC)
   ) tmr_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (out_o),
      .lim_i    (cfg.lim),
      .expire_o (expire)
   );

   tout_out_ctrl ctl_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (cfg_done),
      .toggle_i  (cfg.toggle),
      .touch_i   (touch_i),
      .expire_i  (expire),
      .out_o     (out_o),
      .timeout_o (timeout_o),
      .blk_o     (blk)
   );

endmodule

// File: rtl/touch_out_timer_checker.sv
module touch_out_timer_checker
   import tout_pkg::*;
#(
   parameter int TICK_DIV  = 10_000_000,
   parameter int SHORT_SEC = 10,
   parameter int LONG_SEC  = 60
) (
   input logic      clk,
   input logic      rst_n,
   input logic      touch_i,
   input logic      out_o,
   input logic      timeout_o,
   input logic      cfg_done,
   input tout_cfg_t cfg
);

   int unsigned hi_cnt;
   int unsigned lim_cycles;

   assign lim_cycles = (cfg.lim == LIM_LONG) ? LONG_SEC * TICK_DIV : SHORT_SEC * TICK_DIV;

   always_ff @(posedge clk) begin
      if (!rst_n || !out_o) hi_cnt <= 0;
      else                  hi_cnt <= hi_cnt + 1;
   end

   AST_NO_OUT_UNCONFIG: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_done |-> !out_o && !timeout_o);                               // R2
   AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_done |=> $stable(cfg));                                         // R1
   AST_FOLLOW_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_done && !cfg.toggle && !touch_i |=> !out_o);                    // R7
   AST_ON_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      out_o && cfg.lim != LIM_NONE |-> hi_cnt < lim_cycles);              // R8
   AST_TO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |=> !timeout_o);                                          // R8
   AST_TO_OUT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |-> !out_o);                                              // R8
   AST_BLOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o && touch_i |=> !out_o);                                   // R9
   AST_TOGGLE_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_done && cfg.toggle && !touch_i |=> !$rose(out_o));              // R10

endmodule

bind touch_out_timer touch_out_timer_checker #(
   .TICK_DIV  (TICK_DIV),
   .SHORT_SEC (SHORT_SEC),
   .LONG_SEC  (LONG_SEC)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .touch_i   (touch_i),
   .out_o     (out_o),
   .timeout_o (timeout_o),
   .cfg_done  (cfg_done),
   .cfg       (cfg)
);

// File: tb/touch_out_timer_tb_top.sv
module touch_out_timer_tb_top;

   localparam int DIV   = 8;
   localparam int SHORT = 3;
   localparam int LONG  = 6;
   localparam int SCYC  = SHORT * DIV;
   localparam int LCYC  = LONG * DIV;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic strap_a_i = 1'b0;
   logic strap_b_i = 1'b0;
   logic touch_i = 1'b0;
   logic out_o, timeout_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      logic  o;
      logic  t;
      string req;
   } exp_t;

   exp_t q[$];

   always #2 clk = ~clk;

   touch_out_timer #(
      .TICK_DIV  (DIV),
      .SHORT_SEC (SHORT),
      .LONG_SEC  (LONG)
   ) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .strap_a_i (strap_a_i),
      .strap_b_i (strap_b_i),
      .touch_i   (touch_i),
      .out_o     (out_o),
      .timeout_o (timeout_o)
   );

   // monitor: one expected item per clock edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (out_o !== e.o || timeout_o !== e.t) begin
               errors++;
               $display("FAIL %s: out=%b timeout=%b expected out=%b timeout=%b",
                        e.req, out_o, timeout_o, e.o, e.t);
            end
         end
      end
   end

   task automatic step(input logic tv, input logic eo, input logic et, input string req);
      exp_t e;
      @(negedge clk);
      touch_i = tv;
      e.o = eo; e.t = et; e.req = req;
      q.push_back(e);
   endtask

   task automatic do_reset(input logic a, input logic b, input logic tv);
      exp_t e;
      @(negedge clk);
      rst_n = 1'b0;
      strap_a_i = a;
      strap_b_i = b;
      touch_i = tv;
      repeat (3) @(negedge clk);
      checks++;
      if (out_o !== 1'b0 || timeout_o !== 1'b0) begin
         errors++;
         $display("FAIL R2: in reset out=%b timeout=%b expected out=0 timeout=0", out_o, timeout_o);
      end
      rst_n = 1'b1;
      e.o = 1'b0; e.t = 1'b0; e.req = "R2";
      q.push_back(e);
   endtask

   // hold touch for n edges starting from a released state; lim=0 means no limit
   task automatic press_run(input int n, input int lim, input string req);
      for (int i = 0; i < n; i++)
         step(1'b1, (lim == 0 || i < lim), (lim != 0 && i == lim), req);
   endtask

   task automatic drain;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not finish");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      // R3/R7: follow, unlimited; touch already held at reset release
      do_reset(1'b0, 1'b0, 1'b1);
      press_run(LCYC + 12, 0, "R3");
      step(1'b0, 1'b0, 1'b0, "R7");
      step(1'b1, 1'b1, 1'b0, "R7");
      step(1'b0, 1'b0, 1'b0, "R7");
      step(1'b1, 1'b1, 1'b0, "R7");
      step(1'b1, 1'b1, 1'b0, "R7");
      step(1'b0, 1'b0, 1'b0, "R7");
      drain();

      // R4/R8/R9/R11/R1: follow, short limit
      do_reset(1'b0, 1'b1, 1'b0);
      press_run(10, SCYC, "R4");
      step(1'b0, 1'b0, 1'b0, "R11");
      press_run(SCYC + 6, SCYC, "R11");
      step(1'b0, 1'b0, 1'b0, "R9");
      step(1'b1, 1'b1, 1'b0, "R9");
      strap_a_i = 1'b1;
      strap_b_i = 1'b1;
      step(1'b0, 1'b0, 1'b0, "R1");
      step(1'b1, 1'b1, 1'b0, "R1");
      step(1'b0, 1'b0, 1'b0, "R1");
      drain();

      // R5: follow, long limit
      do_reset(1'b1, 1'b0, 1'b0);
      press_run(LCYC + 7, LCYC, "R5");
      step(1'b0, 1'b0, 1'b0, "R5");
      drain();

      // R6/R10: toggle, short limit
      do_reset(1'b1, 1'b1, 1'b0);
      step(1'b1, 1'b1, 1'b0, "R6");
      for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, "R10");
      step(1'b0, 1'b1, 1'b0, "R10");
      step(1'b1, 1'b0, 1'b0, "R10");
      step(1'b0, 1'b0, 1'b0, "R10");
      // on with touch released, expires on its own
      step(1'b1, 1'b1, 1'b0, "R6");
      for (int i = 1; i < SCYC; i++) step(1'b0, 1'b1, 1'b0, "R6");
      step(1'b0, 1'b0, 1'b1, "R8");
      step(1'b0, 1'b0, 1'b0, "R8");
      step(1'b1, 1'b1, 1'b0, "R10");
      step(1'b0, 1'b1, 1'b0, "R10");
      step(1'b1, 1'b0, 1'b0, "R10");
      step(1'b0, 1'b0, 1'b0, "R10");
      // held through timeout in toggle mode stays blocked
      press_run(SCYC + 5, SCYC, "R9");
      step(1'b0, 1'b0, 1'b0, "R9");
      step(1'b1, 1'b1, 1'b0, "R9");
      drain();

      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule